// File: doc/BRIEF.md
# Colour-Filtered Jump Decode Stage

This stage sits after instruction fetch in a pipeline that handles control hazards by colouring. It holds a single colour bit for the processor. Each fetched item carries an address, a colour tag, an instruction kind (jump or plain) and an immediate. The items arrive over a valid/ready handshake.

When an accepted item's tag differs from the held colour, it belongs to a stream that is already stale. The stage discards it, and the only trace it leaves is a saturating discard counter. A matching plain item goes on to the execute port, and the colour does not change. A matching jump flips the held colour. It also raises a redirect that carries the word-aligned destination, taken from the immediate, together with the new colour. The fetch side uses that colour to tag the new stream.

While a redirect waits to be accepted, the stage accepts no further input. Both output ports are registered, so an item accepted at one clock edge shows up on its output port after that edge.

Top module: `cdec_stage`

## Requirements
- R1: After reset, colour_o is 0, rd_valid_o and ex_valid_o are 0, drop_count_o is 0, and in_ready_o is 1.
- R2: An accepted item with in_kind_i = 1 (jump) and in_colour_i equal to colour_o inverts colour_o at that edge. After the same edge, rd_valid_o is 1 and rd_colour_o equals the inverted colour.
- R3: An accepted item with in_kind_i = 0 (plain) and a matching colour appears after that edge on ex_valid_o = 1, with ex_addr_o equal to in_addr_i. colour_o is unchanged.
- R4: An accepted item whose in_colour_i differs from colour_o produces no output on either port and leaves colour_o unchanged. It increments drop_count_o by one.
- R5: While rd_valid_o is 1, in_ready_o is 0.
- R6: While rd_valid_o is 1 and rd_ready_i is 0, rd_valid_o, rd_addr_o and rd_colour_o stay unchanged over the next edge.
- R7: While ex_valid_o is 1 and ex_ready_i is 0, in_ready_o is 0, and ex_valid_o and ex_addr_o stay unchanged over the next edge. Otherwise, with no redirect pending, in_ready_o is 1.
- R8: rd_addr_o equals in_imm_i of the jump with bits [1:0] forced to 0, so destinations are always multiples of four.
- R9: drop_count_o saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Fetched item valid |
| in_ready_o | output | 1 | Stage can take an item |
| in_addr_i | input | AW | Fetch address of the item |
| in_colour_i | input | 1 | Colour tag of the item |
| in_kind_i | input | 1 | 1 = jump, 0 = plain |
| in_imm_i | input | AW | Jump destination immediate |
| ex_valid_o | output | 1 | Item offered to execute |
| ex_ready_i | input | 1 | Execute accepts |
| ex_addr_o | output | AW | Address of the offered item |
| rd_valid_o | output | 1 | Redirect pending |
| rd_ready_i | input | 1 | Fetch accepts redirect |
| rd_addr_o | output | AW | Redirect destination |
| rd_colour_o | output | 1 | Colour for the new stream |
| colour_o | output | 1 | Currently held colour |
| drop_count_o | output | CW | Saturating count of discarded items |

## Verification
The random traffic mixes matching and stale colour tags with jump and plain kinds, under randomly throttled readies on both output ports. This separates the three outcomes of pass, redirect and discard, and shows whether back-pressure on one port wrongly blocks or leaks the other. A directed jump with a misaligned immediate, held against a stalled redirect port, separates correct alignment and stable holding from a redirect that is lost or altered. A long run of stale items separates saturation of the discard count from wraparound.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  typedef enum logic {
    KIND_PLAIN = 1'b0,
    KIND_JUMP  = 1'b1
  } kind_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_PASS,
    ACT_REDIRECT,
    ACT_DROP
  } act_e;
endpackage

// File: rtl/cdec_classify.sv
module cdec_classify
  import cdec_pkg::*;
(
  input  logic fire_i,
  input  logic tag_i,
  input  logic cur_i,
  input  logic kind_i,
  output act_e act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (fire_i) begin
      if (tag_i != cur_i)             act_o = ACT_DROP;
      else if (kind_i == KIND_JUMP)   act_o = ACT_REDIRECT;
      else                            act_o = ACT_PASS;
    end
  end
endmodule

// File: rtl/cdec_colour_reg.sv
module cdec_colour_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  output logic colour_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     colour_o <= 1'b0;
    else if (flip_i) colour_o <= ~colour_o;
  end
endmodule

// File: rtl/cdec_slot.sv
module cdec_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cdec_drop_ctr.sv
module cdec_drop_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      count_o <= '0;
    else if (inc_i && count_o != MAX) count_o <= count_o + 1'b1;
  end

  AST_DROP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == MAX |=> count_o == MAX); // R9
endmodule

// File: rtl/cdec_stage.sv
module cdec_stage
  import cdec_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [AW-1:0] in_addr_i,
  input  logic          in_colour_i,
  input  logic          in_kind_i,
  input  logic [AW-1:0] in_imm_i,
  output logic          ex_valid_o,
  input  logic          ex_ready_i,
  output logic [AW-1:0] ex_addr_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_colour_o,
  output logic          colour_o,
  output logic [CW-1:0] drop_count_o
);
  localparam int unsigned RW = AW + 1;

  logic          fire;
  act_e          act;
  logic [AW-1:0] target;
  logic [RW-1:0] rd_data;

  // a pending redirect blocks everything; execute slot needs room or a drain
  assign in_ready_o = !rd_valid_o && (!ex_valid_o || ex_ready_i);
  assign fire       = in_valid_i && in_ready_o;
  assign target     = {in_imm_i[AW-1:2], 2'b00};

  cdec_classify u_cls (
    .fire_i (fire),
    .tag_i  (in_colour_i),
    .cur_i  (colour_o),
    .kind_i (in_kind_i),
    .act_o  (act)
  );

  cdec_colour_reg u_col (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flip_i   (act == ACT_REDIRECT),
    .colour_o (colour_o)
  );

  cdec_slot #(.W(RW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (act == ACT_REDIRECT),
    .data_i  ({~colour_o, target}),
    .ready_i (rd_ready_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data)
  );
  assign rd_addr_o   = rd_data[AW-1:0];
  assign rd_colour_o = rd_data[AW];

  cdec_slot #(.W(AW)) u_ex (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (act == ACT_PASS),
    .data_i  (in_addr_i),
    .ready_i (ex_ready_i),
    .valid_o (ex_valid_o),
    .data_o  (ex_addr_o)
  );

  cdec_drop_ctr #(.CW(CW)) u_drop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (act == ACT_DROP),
    .count_o (drop_count_o)
  );

  AST_COLOUR_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_kind_i && in_colour_i == colour_o)
      |=> colour_o != $past(colour_o)); // R2
  AST_RD_NEW_COLOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_colour_o == colour_o); // R2
  AST_COLOUR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o && in_kind_i && in_colour_i == colour_o)
      |=> $stable(colour_o)); // R4
  AST_STALL_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !in_ready_o); // R5
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o) && $stable(rd_colour_o)); // R6
  AST_EX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o && !ex_ready_i |=> ex_valid_o && $stable(ex_addr_o)); // R7
  AST_RD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_addr_o[1:0] == 2'b00); // R8
endmodule

// File: tb/cdec_stage_test.sv
`timescale 1ns/1ps
module cdec_stage_test;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0, in_colour_i = 1'b0, in_kind_i = 1'b0;
  logic [AW-1:0] in_addr_i = '0, in_imm_i = '0;
  logic          ex_ready_i = 1'b0, rd_ready_i = 1'b0;
  logic          in_ready_o, ex_valid_o, rd_valid_o, rd_colour_o, colour_o;
  logic [AW-1:0] ex_addr_o, rd_addr_o;
  logic [CW-1:0] drop_count_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic          m_col = 0, m_rdv = 0, m_rdc = 0, m_exv = 0;
  logic [AW-1:0] m_rda = '0, m_exa = '0, m_pc = '0;
  logic [CW-1:0] m_drops = '0;

  always #2.5 clk = ~clk;

  cdec_stage #(.AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_addr_i(in_addr_i),
    .in_colour_i(in_colour_i), .in_kind_i(in_kind_i), .in_imm_i(in_imm_i),
    .ex_valid_o(ex_valid_o), .ex_ready_i(ex_ready_i), .ex_addr_o(ex_addr_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_colour_o(rd_colour_o), .colour_o(colour_o), .drop_count_o(drop_count_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ready(input logic ex_rdy);
    return !m_rdv && (!m_exv || ex_rdy);
  endfunction

  function automatic logic [AW-1:0] align4(input logic [AW-1:0] v);
    return {v[AW-1:2], 2'b00};
  endfunction

  task automatic step(input logic vld, input logic col, input logic kind,
                      input logic [AW-1:0] addr, input logic [AW-1:0] imm,
                      input logic rrdy, input logic erdy);
    logic rdy, fire;
    @(negedge clk);
    in_valid_i = vld; in_colour_i = col; in_kind_i = kind;
    in_addr_i = addr; in_imm_i = imm; rd_ready_i = rrdy; ex_ready_i = erdy;
    #0.5;
    rdy = exp_ready(erdy);
    chk(m_rdv ? "R5 in_ready" : "R7 in_ready", {31'b0, in_ready_o}, {31'b0, rdy});
    fire = vld && rdy;
    if (m_rdv && rrdy) m_rdv = 0;
    if (m_exv && erdy) m_exv = 0;
    if (fire) begin
      if (col != m_col) begin
        if (m_drops != '1) m_drops = m_drops + 1'b1;
      end else if (kind) begin
        m_col = ~m_col; m_rdv = 1; m_rdc = m_col; m_rda = align4(imm);
      end else begin
        m_exv = 1; m_exa = addr;
      end
    end
    @(posedge clk); #1;
    chk("R2 R4 colour", {31'b0, colour_o}, {31'b0, m_col});
    chk("R2 rd_valid", {31'b0, rd_valid_o}, {31'b0, m_rdv});
    if (m_rdv) begin
      chk("R8 rd_addr", rd_addr_o, m_rda);
      chk("R6 rd_colour", {31'b0, rd_colour_o}, {31'b0, m_rdc});
    end
    chk("R3 ex_valid", {31'b0, ex_valid_o}, {31'b0, m_exv});
    if (m_exv) chk("R7 ex_addr", ex_addr_o, m_exa);
    chk(m_drops == '1 ? "R9 drops" : "R4 drops", {24'b0, drop_count_o}, {24'b0, m_drops});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    #12 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 colour", {31'b0, colour_o}, 32'd0);
    chk("R1 rd_valid", {31'b0, rd_valid_o}, 32'd0);
    chk("R1 ex_valid", {31'b0, ex_valid_o}, 32'd0);
    chk("R1 drops", {24'b0, drop_count_o}, 32'd0);
    chk("R1 in_ready", {31'b0, in_ready_o}, 32'd1);

    // R3 plain items at sequential addresses
    for (int i = 0; i < 4; i++) begin
      step(1, m_col, 0, m_pc, 0, 1, 1);
      m_pc = m_pc + 4;
    end
    // R8 R6 R5 misaligned jump with stalled redirect port
    step(1, m_col, 1, m_pc, 32'h0000_1003, 0, 1);
    for (int i = 0; i < 3; i++) step(1, m_col, 0, m_pc, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    // R4 stale item after the flip
    step(1, ~m_col, 0, 32'h40, 0, 1, 1);
    step(1, ~m_col, 1, 32'h44, 32'h80, 1, 1);
    // R7 execute stall
    step(1, m_col, 0, 32'h100, 0, 1, 0);
    step(1, m_col, 0, 32'h104, 0, 1, 0);
    step(1, m_col, 0, 32'h108, 0, 1, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic c;
      c = ($urandom_range(9) < 7) ? m_col : ~m_col;
      step($urandom_range(3) != 0, c, $urandom_range(3) == 0, $urandom,
           $urandom, $urandom_range(2) != 0, $urandom_range(2) != 0);
    end

    // R9 saturation with stale items
    for (int i = 0; i < 300; i++) step(1, ~m_col, i[0], 32'h200, 32'h300, 1, 1);
    chk("R9 saturated", {24'b0, drop_count_o}, {24'b0, {CW{1'b1}}});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule